// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is the fastest stage of a decimal counting chain. A divide-by-2 stage comes first, and a five-stage one-hot ring counts its completed cycles. Encode logic turns the pair into a BCD digit. Each cycle with the count enable high is one input event. Ten events make one full turn of divider and ring. The block then emits a one-cycle carry that clocks the next decade of the chain.

The ring holds exactly one active stage. Each active position stands for two counts. The BCD value is therefore recovered by encoding (twice the ring position plus the divider bit) and is not kept in a binary register. A synchronous clear returns the decade to zero. A ring that has lost its one-hot form is put back to position 0 on its next advance.

Top module: `bq_decade`

## Requirements
- R1: Each clock cycle with `en` high and `clr` low toggles the divider, so the count rises by exactly one per enabled cycle.
- R2: `digit` equals 2 × ring position + divider bit. Ring position k is the single set bit k of the ring, and the divider bit is the digit's least significant bit. Over ten events the digit steps 0,1,...,9 and stays within 0 to 9. The digit is registered and shows the new count after the same edge that takes the event.
- R3: With `en` low and `clr` low, `digit` and the internal state hold their values.
- R4: `clr` high sets the divider to 0 and the ring to position 0, giving `digit` 0 after the edge, and takes priority over `en`. No carry is produced.
- R5: `carry` is high for exactly one cycle, the cycle in which `digit` returns from 9 to 0 on an event. At all other times it is low.
- R6: The ring moves one position only on an event that takes the divider from 1 to 0, and after every such move it holds exactly one set bit.
- R7: A ring holding no set bit, or more than one, is reloaded with position 0 at its next advance, and counting continues normally from digit 0.
- R8: `rst` is synchronous and active high. It leaves `digit` at 0 and `carry` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the decade |
| en | input | 1 | Count enable; each high cycle is one input event |
| digit | output | 4 | Registered BCD count |
| carry | output | 1 | One-cycle pulse on wrap from 9 to 0 |

## Verification
A table of enable/clear patterns runs the decade through a full 0-to-9 wrap. It includes idle gaps mid-count, which separate a held value from a skipped event, and clear asserted together with enable, which shows that clear wins. A 100-event run counts the carry pulses and confirms that ten events make exactly one carry. Directed cases corrupt the ring to an all-zero pattern and to a two-hot pattern just before an advance. This shows that the recovery lands on digit 0 and does not produce a false carry.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int unsigned BQ_RING_LEN = 5;
  localparam int unsigned BQ_DIGIT_W  = 4;

  function automatic logic [BQ_RING_LEN-1:0] ring_home();
    logic [BQ_RING_LEN-1:0] r;
    r = '0;
    r[0] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/bq_div2.sv
module bq_div2 (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic div_q,
  output logic div_d,
  output logic adv
);
  always_comb begin
    if (clr)     div_d = 1'b0;
    else if (en) div_d = ~div_q;
    else         div_d = div_q;
  end

  // ring advances when the divider falls from 1 to 0
  assign adv = en & div_q & ~clr;

  always_ff @(posedge clk) div_q <= div_d;

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (div_q != $past(div_q))); // R1
endmodule

// File: rtl/bq_ring.sv
module bq_ring #(
  parameter int unsigned RING_LEN = bq_pkg::BQ_RING_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                adv,
  output logic [RING_LEN-1:0] ring_q,
  output logic [RING_LEN-1:0] ring_d
);
  logic [RING_LEN-1:0] rot;
  logic                valid;

  genvar g;
  generate
    for (g = 0; g < RING_LEN; g++) begin : g_rot
      if (g == 0) begin : g_wrap
        assign rot[g] = ring_q[RING_LEN-1];
      end else begin : g_shift
        assign rot[g] = ring_q[g-1];
      end
    end
  endgenerate

  assign valid = $onehot(ring_q);

  always_comb begin
    if (clr)      ring_d = bq_pkg::ring_home();
    else if (adv) ring_d = valid ? rot : bq_pkg::ring_home();
    else          ring_d = ring_q;
  end

  always_ff @(posedge clk) ring_q <= ring_d;

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    adv |=> $onehot(ring_q)); // R6
endmodule

// File: rtl/bq_encode.sv
module bq_encode #(
  parameter int unsigned RING_LEN = bq_pkg::BQ_RING_LEN,
  parameter int unsigned DIGIT_W  = bq_pkg::BQ_DIGIT_W
) (
  input  logic [RING_LEN-1:0] ring,
  input  logic                div,
  output logic [DIGIT_W-1:0]  digit
);
  localparam int unsigned POS_W = $clog2(RING_LEN);

  logic [POS_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < RING_LEN; i++) begin
      if (ring == (RING_LEN'(1) << i)) pos = POS_W'(i);
    end
    digit = DIGIT_W'({pos, 1'b0}) + DIGIT_W'(div);
  end
endmodule

// File: rtl/bq_decade.sv
module bq_decade #(
  parameter int unsigned RING_LEN = bq_pkg::BQ_RING_LEN,
  parameter int unsigned DIGIT_W  = bq_pkg::BQ_DIGIT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  output logic [DIGIT_W-1:0] digit,
  output logic               carry
);
  localparam int unsigned LAST = RING_LEN - 1;

  logic                clr_all;
  logic                div_q, div_d, adv;
  logic [RING_LEN-1:0] ring_q, ring_d;
  logic [DIGIT_W-1:0]  digit_d;

  assign clr_all = rst | clr;

  bq_div2 u_div (
    .clk(clk), .rst(rst), .clr(clr_all), .en(en),
    .div_q(div_q), .div_d(div_d), .adv(adv)
  );

  bq_ring #(.RING_LEN(RING_LEN)) u_ring (
    .clk(clk), .rst(rst), .clr(clr_all), .adv(adv),
    .ring_q(ring_q), .ring_d(ring_d)
  );

  bq_encode #(.RING_LEN(RING_LEN), .DIGIT_W(DIGIT_W)) u_enc (
    .ring(ring_d), .div(div_d), .digit(digit_d)
  );

  always_ff @(posedge clk) begin
    if (clr_all) begin
      digit <= '0;
      carry <= 1'b0;
    end else begin
      digit <= digit_d;
      carry <= adv & ring_q[LAST];
    end
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    digit <= DIGIT_W'(2 * RING_LEN - 1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(digit)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (digit == '0 && !carry)); // R4
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
    carry |-> (digit == '0)); // R5
  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    carry |=> !carry); // R5
endmodule

// File: tb/sim_bq_decade.sv
module sim_bq_decade;
  localparam int CLK_P = 10;
  localparam int NV = 18;
  // each entry: {en, clr, digit[3:0], carry}
  localparam logic [6:0] VEC [NV] = '{
    7'b10_0001_0, 7'b10_0010_0, 7'b10_0011_0, 7'b00_0011_0,
    7'b10_0100_0, 7'b10_0101_0, 7'b10_0110_0, 7'b10_0111_0,
    7'b10_1000_0, 7'b10_1001_0, 7'b10_0000_1, 7'b00_0000_0,
    7'b10_0001_0, 7'b10_0010_0, 7'b11_0000_0, 7'b10_0001_0,
    7'b01_0000_0, 7'b10_0001_0
  };

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, en = 1'b0;
  logic [3:0] digit;
  logic       carry;
  int errs = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  bq_decade u0 (.clk(clk), .rst(rst), .clr(clr), .en(en), .digit(digit), .carry(carry));

  task automatic check(input string req, input logic [3:0] ed, input logic ec);
    checks++;
    if (digit !== ed || carry !== ec) begin
      errs++;
      $display("FAIL %s: digit=%0d carry=%0b expected digit=%0d carry=%0b", req, digit, carry, ed, ec);
    end
  endtask

  task automatic step(input logic e, input logic c);
    en = e; clr = c;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; clr = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic wrap_up();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    wrap_up();
  end

  initial begin
    int carries;
    do_reset();
    check("R8 reset", 4'd0, 1'b0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5]);
      check("R1/R2/R3/R4/R5 vector", VEC[i][4:1], VEC[i][0]);
    end

    // R8: reset in mid-count
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    rst = 1'b1; step(1'b1, 1'b0); rst = 1'b0;
    check("R8 mid-count reset", 4'd0, 1'b0);

    // R2 R5 R6: long run, ten events per carry
    carries = 0;
    for (int i = 1; i <= 100; i++) begin
      step(1'b1, 1'b0);
      if (carry) carries++;
      check("R2 long run digit", 4'(i % 10), (i % 10) == 0);
    end
    checks++;
    if (carries != 10) begin
      errs++;
      $display("FAIL R6 carry count: got %0d expected 10", carries);
    end

    // R7: two-hot ring reloaded at next advance (digit 3 -> div=1)
    do_reset();
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    check("R7 setup", 4'd3, 1'b0);
    force u0.u_ring.ring_q = 5'b00110;
    #1 release u0.u_ring.ring_q;
    step(1'b1, 1'b0);
    check("R7 two-hot recovery", 4'd0, 1'b0);
    step(1'b1, 1'b0);
    check("R7 continue after recovery", 4'd1, 1'b0);

    // R7: empty ring reloaded at next advance
    force u0.u_ring.ring_q = 5'b00000;
    #1 release u0.u_ring.ring_q;
    step(1'b1, 1'b0);
    check("R7 empty recovery", 4'd0, 1'b0);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    check("R7 count after empty recovery", 4'd2, 1'b0);

    // R4: clear at digit 9 beats the wrap, no carry
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0);
    check("R2 reach nine", 4'd9, 1'b0);
    step(1'b1, 1'b1);
    check("R4 clear at nine", 4'd0, 1'b0);

    wrap_up();
  end
endmodule